// File: doc/BRIEF.md
# Scanline-Counting Interrupt Generator

This block counts video scanlines and raises an interrupt request once a programmed number of lines has gone by. Software writes a reload value into an 8-bit latch and asks for a reload through a small write port. It then arms the request. Another block detects scanlines and sends them in as one-cycle pulses. Each pulse either reloads the down-counter or decrements it. When the counter ends a pulse at zero while the generator is armed, a registered level request goes high. That request stays high until software writes the disarm command.

The write port carries four things: a 2-bit group code standing for a decoded address range, the low address bit, a data byte and a strobe. Group 2 selects the counter registers. An even write there sets the latch, and an odd write requests a reload. Group 3 selects the arm controls. An even write there disarms and clears the request, and an odd write arms. Group codes 0 and 1 are ignored.

Top module: `irq_scanline_gen`

## Requirements
- R1: A strobed write with group code 2 and address bit 0 low stores the data byte in the latch, and the counter does not change in that cycle.
- R2: A strobed write with group code 2 and address bit 0 high sets a pending-reload flag. The counter does not change until the next scanline pulse.
- R3: On a scanline pulse, if the counter is 0 or a reload is pending, the counter takes the latch value and the pending flag clears.
- R4: On a scanline pulse when the counter is nonzero and no reload is pending, the counter decrements by one.
- R5: If the counter is 0 after a pulse's update and the generator is armed, the request output is high from the next clock edge, and the counter stays at 0.
- R6: Once high, the request stays high across later pulses and other writes until a disarm write.
- R7: A strobed write with group code 3 and address bit 0 low disarms the generator and drives the request low from the next edge.
- R8: A strobed write with group code 3 and address bit 0 high arms the generator and leaves the request level unchanged.
- R9: Writes with group code 0 or 1, and any cycle with the strobe low, change no state.
- R10: When a write and a scanline pulse arrive in the same cycle, the write is applied first and the pulse acts on the updated latch, pending and arm state.
- R11: Synchronous active-high reset clears the counter, the latch, the pending flag and the arm flag, and drives the request low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Write strobe |
| wr_grp | input | 2 | Address range group code (2 = counter registers, 3 = arm controls) |
| wr_a0 | input | 1 | Low address bit that selects the register within a group |
| wr_data | input | 8 | Write data |
| line_pulse | input | 1 | One-cycle scanline pulse |
| irq_o | output | 1 | Level interrupt request |

## Verification
A register write and a scanline pulse can land in the same cycle. The three cases that matter are:
- a reload request or latch write together with a pulse;
- an arm write together with a pulse that ends at zero;
- a disarm write together with a pulse that ends at zero.

Directed steps create each of these cases on purpose, and random steps with small latch values create many more. A cycle-level reference model in the bench applies the write before the pulse and predicts the request level after every edge. The design output is compared with that prediction.

// File: rtl/irqsl_pkg.sv
package irqsl_pkg;

    localparam int CNT_W = 8;
    localparam int GRP_W = 2;

    localparam logic [GRP_W-1:0] GRP_CNT = 2'd2;
    localparam logic [GRP_W-1:0] GRP_ARM = 2'd3;

    typedef struct packed {
        logic latch_wr;
        logic reload_req;
        logic arm;
        logic disarm;
    } irqsl_cmd_t;

    function automatic irqsl_cmd_t decode_cmd(
        input logic             stb,
        input logic [GRP_W-1:0] grp,
        input logic             a0
    );
        irqsl_cmd_t c;
        c = '0;
        if (stb) begin
            if (grp == GRP_CNT) begin
                c.latch_wr   = !a0;
                c.reload_req = a0;
            end else if (grp == GRP_ARM) begin
                c.disarm = !a0;
                c.arm    = a0;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/irqsl_wr_decode.sv
module irqsl_wr_decode
    import irqsl_pkg::*;
(
    input  logic             wr_stb,
    input  logic [GRP_W-1:0] wr_grp,
    input  logic             wr_a0,
    output irqsl_cmd_t       cmd
);
    always_comb begin
        cmd = decode_cmd(wr_stb, wr_grp, wr_a0);
    end
endmodule

// File: rtl/irqsl_line_counter.sv
module irqsl_line_counter
    import irqsl_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  irqsl_cmd_t   cmd,
    input  logic [W-1:0] wr_data,
    input  logic         line_pulse,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] latch_q,
    output logic         pend_q,
    output logic         zero_hit
);
    logic [W-1:0] latch_n;
    logic [W-1:0] cnt_n;
    logic         pend_eff;
    logic         pend_n;

    always_comb begin
        latch_n  = cmd.latch_wr ? wr_data : latch_q;
        pend_eff = pend_q | cmd.reload_req;
        cnt_n    = cnt_q;
        pend_n   = pend_eff;
        if (line_pulse) begin
            if ((cnt_q == '0) || pend_eff) begin
                cnt_n  = latch_n;
                pend_n = 1'b0;
            end else begin
                cnt_n = cnt_q - W'(1);
            end
        end
        zero_hit = line_pulse && (cnt_n == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            latch_q <= '0;
            pend_q  <= 1'b0;
        end else begin
            cnt_q   <= cnt_n;
            latch_q <= latch_n;
            pend_q  <= pend_n;
        end
    end
endmodule

// File: rtl/irqsl_req_flag.sv
module irqsl_req_flag
    import irqsl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  irqsl_cmd_t cmd,
    input  logic       zero_hit,
    output logic       en_q,
    output logic       irq_q
);
    logic en_n;
    logic irq_n;

    always_comb begin
        en_n = en_q;
        if (cmd.arm)    en_n = 1'b1;
        if (cmd.disarm) en_n = 1'b0;
        if (cmd.disarm) irq_n = 1'b0;
        else            irq_n = irq_q | (zero_hit & en_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            en_q  <= en_n;
            irq_q <= irq_n;
        end
    end
endmodule

// File: rtl/irq_scanline_gen.sv
module irq_scanline_gen
    import irqsl_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_stb,
    input  logic [GRP_W-1:0] wr_grp,
    input  logic             wr_a0,
    input  logic [W-1:0]     wr_data,
    input  logic             line_pulse,
    output logic             irq_o
);
    irqsl_cmd_t   cmd;
    logic [W-1:0] cnt_q;
    logic [W-1:0] latch_q;
    logic         pend_q;
    logic         zero_hit;
    logic         en_q;
    logic         irq_q;

    irqsl_wr_decode u_dec (
        .wr_stb (wr_stb),
        .wr_grp (wr_grp),
        .wr_a0  (wr_a0),
        .cmd    (cmd)
    );

    irqsl_line_counter #(.W(W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .wr_data    (wr_data),
        .line_pulse (line_pulse),
        .cnt_q      (cnt_q),
        .latch_q    (latch_q),
        .pend_q     (pend_q),
        .zero_hit   (zero_hit)
    );

    irqsl_req_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .zero_hit (zero_hit),
        .en_q     (en_q),
        .irq_q    (irq_q)
    );

    assign irq_o = irq_q;
endmodule

// File: rtl/irq_scanline_gen_chk.sv
module irq_scanline_gen_chk
    import irqsl_pkg::*;
#(
    parameter int W = CNT_W
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_stb,
    input logic [GRP_W-1:0] wr_grp,
    input logic             wr_a0,
    input logic [W-1:0]     wr_data,
    input logic             line_pulse,
    input logic             irq_o,
    input logic [W-1:0]     cnt_q,
    input logic [W-1:0]     latch_q,
    input logic             pend_q,
    input logic             en_q
);
    logic w_latch, w_reload, w_arm, w_disarm, w_none;
    assign w_latch  = wr_stb && wr_grp == GRP_CNT && !wr_a0;
    assign w_reload = wr_stb && wr_grp == GRP_CNT && wr_a0;
    assign w_arm    = wr_stb && wr_grp == GRP_ARM && wr_a0;
    assign w_disarm = wr_stb && wr_grp == GRP_ARM && !wr_a0;
    assign w_none   = !(w_latch || w_reload || w_arm || w_disarm);

    AST_LATCH_STORE: assert property (@(posedge clk) disable iff (rst)
        w_latch |=> latch_q == $past(wr_data)); // R1
    AST_NO_PULSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !line_pulse |=> $stable(cnt_q)); // R2
    AST_RELOAD_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
        line_pulse && !w_latch && (cnt_q == '0) |=> cnt_q == $past(latch_q) && !pend_q); // R3
    AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        line_pulse && cnt_q != '0 && !pend_q && !w_reload |=> cnt_q == $past(cnt_q) - W'(1)); // R4
    AST_FIRE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> cnt_q == '0 && en_q); // R5
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        irq_o && !w_disarm |=> irq_o); // R6
    AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
        w_disarm |=> !irq_o && !en_q); // R7
    AST_ARM_SETS: assert property (@(posedge clk) disable iff (rst)
        w_arm |=> en_q); // R8
    AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (rst)
        w_none && !line_pulse |=> $stable(latch_q) && $stable(en_q) && $stable(pend_q) && $stable(irq_o)); // R9
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> cnt_q == '0 && latch_q == '0 && !irq_o && !en_q && !pend_q); // R11
endmodule

bind irq_scanline_gen irq_scanline_gen_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_stb     (wr_stb),
    .wr_grp     (wr_grp),
    .wr_a0      (wr_a0),
    .wr_data    (wr_data),
    .line_pulse (line_pulse),
    .irq_o      (irq_o),
    .cnt_q      (cnt_q),
    .latch_q    (latch_q),
    .pend_q     (pend_q),
    .en_q       (en_q)
);

// File: tb/irq_scanline_gen_bench.sv
module irq_scanline_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_stb = 1'b0;
    logic [1:0]   wr_grp = 2'd0;
    logic         wr_a0 = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         line_pulse = 1'b0;
    logic         irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference state
    logic [W-1:0] m_cnt, m_latch;
    logic         m_pend, m_en, m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_scanline_gen #(.W(W)) u_irq_scanline_gen (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_grp(wr_grp), .wr_a0(wr_a0),
        .wr_data(wr_data), .line_pulse(line_pulse), .irq_o(irq_o)
    );

    task automatic model_reset();
        m_cnt = '0; m_latch = '0; m_pend = 0; m_en = 0; m_irq = 0;
    endtask

    // write first, then pulse (R10)
    task automatic model_step(input logic stb, input logic [1:0] grp, input logic a0,
                              input logic [W-1:0] d, input logic p);
        if (stb && grp == 2'd2 && !a0) m_latch = d;
        if (stb && grp == 2'd2 && a0)  m_pend = 1;
        if (stb && grp == 2'd3 && a0)  m_en = 1;
        if (stb && grp == 2'd3 && !a0) begin m_en = 0; m_irq = 0; end
        if (p) begin
            if (m_cnt == 0 || m_pend) begin m_cnt = m_latch; m_pend = 0; end
            else m_cnt = m_cnt - 1;
            if (m_cnt == 0 && m_en) m_irq = 1;
        end
    endtask

    task automatic check(input string tag);
        n_chk++;
        if (irq_o !== m_irq) begin
            n_fail++;
            $display("FAIL %s: irq_o actual=%b expected=%b at %0t", tag, irq_o, m_irq, $time);
        end
    endtask

    // called at a negedge; returns at the following negedge after checking
    task automatic step(input logic stb, input logic [1:0] grp, input logic a0,
                        input logic [W-1:0] d, input logic p, input string tag);
        wr_stb = stb; wr_grp = grp; wr_a0 = a0; wr_data = d; line_pulse = p;
        @(posedge clk);
        model_step(stb, grp, a0, d, p);
        @(negedge clk);
        wr_stb = 0; line_pulse = 0;
        check(tag);
    endtask

    task automatic do_reset(input string tag);
        rst = 1;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 0;
        check(tag);
    endtask

    task automatic pulse(input string tag);
        step(0, 2'd0, 0, '0, 1, tag);
    endtask

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        do_reset("R11 reset state");

        // R1/R2/R3/R4/R5 basic countdown with latch 3
        step(1, 2'd2, 0, 8'd3, 0, "R1 latch write");
        step(1, 2'd2, 1, 8'd0, 0, "R2 reload request");
        step(1, 2'd3, 1, 8'd0, 0, "R8 arm");
        pulse("R3 reload from pending");
        pulse("R4 decrement 3->2");
        pulse("R4 decrement 2->1");
        pulse("R5 reach zero raises request");
        pulse("R6 request held on reload");
        pulse("R6 request held on decrement");
        step(1, 2'd3, 1, 8'd0, 0, "R8 arm keeps request");
        step(1, 2'd2, 0, 8'd9, 0, "R6 latch write keeps request");
        step(1, 2'd3, 0, 8'd0, 0, "R7 disarm clears request");
        pulse("R7 disarmed pulse");

        // R9 ignored groups and no strobe
        step(1, 2'd0, 0, 8'd0, 0, "R9 group 0 even");
        step(1, 2'd1, 1, 8'd0, 0, "R9 group 1 odd");
        step(0, 2'd3, 0, 8'd0, 0, "R9 strobe low disarm");
        step(0, 2'd2, 0, 8'd1, 0, "R9 strobe low latch");
        for (int i = 0; i < 12; i++) pulse("R9 latch unchanged countdown");

        // R10 same-cycle cases
        do_reset("R11 reset again");
        step(1, 2'd2, 0, 8'd5, 0, "R1 latch 5");
        step(1, 2'd3, 1, 8'd0, 0, "R8 arm");
        pulse("R3 zero loads 5");
        step(1, 2'd2, 0, 8'd0, 0, "R1 latch 0");
        step(1, 2'd2, 1, 8'd0, 1, "R10 reload with pulse fires");
        step(1, 2'd3, 0, 8'd0, 0, "R7 disarm");
        step(1, 2'd2, 0, 8'd1, 1, "R10 latch with pulse at zero");
        step(1, 2'd3, 1, 8'd0, 1, "R10 arm with pulse reaching zero");
        step(1, 2'd3, 0, 8'd0, 0, "R7 disarm");
        step(1, 2'd2, 0, 8'd0, 0, "R1 latch 0");
        step(1, 2'd3, 0, 8'd0, 1, "R10 disarm with pulse at zero");
        step(1, 2'd3, 1, 8'd0, 0, "R8 arm no change");
        step(1, 2'd3, 1, 8'd0, 1, "R5 zero latch fires each pulse");
        do_reset("R11 reset clears request");
        step(1, 2'd3, 1, 8'd0, 0, "R8 arm after reset");
        pulse("R11 latch cleared so pulse fires");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic stb, a0, p;
            logic [1:0] g;
            logic [W-1:0] d;
            stb = ($urandom % 10) < 3;
            g   = 2'($urandom % 4);
            a0  = 1'($urandom % 2);
            d   = (($urandom % 4) == 0) ? W'($urandom) : W'($urandom % 5);
            p   = ($urandom % 2) == 1;
            if (stb && g == 2'd3 && !a0 && ($urandom % 3) != 0) a0 = 1;
            if (($urandom % 400) == 0) do_reset("R11 random reset");
            else step(stb, g, a0, d, p, "R10 random mix");
        end

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule